// File: doc/BRIEF.md
# Processor Power-Down Sequencer

This block decides when the core clock domains of a processor may be stopped and when they must run again. Software asks for power-down by moving a control bit from 1 to 0. The block then waits until the memory pipeline reports that it is empty, and only then switches off the core clock enables. While the core is stopped, the always-on domains keep their clock enables set. These domains hold the timer, I/O control, interrupt and refresh logic.

While the core is stopped, a refresh or bus-arbitration request wakes the core clocks for a short service window. That window ends when a done input is seen, and the block then goes back to sleep by itself. An interrupt ends power-down for good. It also cancels an entry that is still waiting for the pipeline. The interrupt wake-up leaves the control bit untouched, so software must raise the bit again and then lower it to request another power-down.

The state is held in registers and all outputs are decoded from that state. All transitions take effect on the clock edge that follows the edge at which their cause is sampled.

Top module: `pwr_down_seq`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after it is released, every bit of `core_clk_en_o` is 1, every bit of `aon_clk_en_o` is 1 and `pd_state_o` is 0. During reset the control bit is taken as 1. A 0 on `pd_ctrl_i` at the first edge after reset is therefore a 1-to-0 transition.
- R2: A power-down request is a 1-to-0 change of `pd_ctrl_i` between two consecutive sampling edges. When `pd_ctrl_i` simply stays at 0, no request is made. `pd_ctrl_i` must be sampled as 1 at least once before a new fall can count.
- R3: After a request, the block waits and sleeps from the edge that follows the first edge at which `pipe_empty_i` is sampled high. This first edge is at the earliest one edge after the request edge. While the block waits, `core_clk_en_o` stays all ones.
- R4: In power-down, every bit of `core_clk_en_o` is 0 and `pd_state_o` is 1. `pd_state_o` is 1 exactly when `core_clk_en_o` is all zeros, and 0 exactly when it is all ones.
- R5: In power-down, if `refresh_req_i` or `arb_req_i` is sampled high without an interrupt, `core_clk_en_o` goes to all ones and `pd_state_o` goes to 0 from the next cycle. This lasts until `svc_done_i` is sampled high. The block then returns to power-down on the next cycle, with no new 1-to-0 transition.
- R6: If `irq_i` is sampled high while waiting for the pipeline, in power-down, or in a service window, the block becomes active on the next cycle. An interrupt takes priority over `pipe_empty_i`, `svc_done_i` and service requests.
- R7: If `irq_i` is high at the same edge as a 1-to-0 transition in the active state, the request is dropped. After any interrupt wake-up, the block stays active while `pd_ctrl_i` remains 0.
- R8: Some inputs are ignored in power-down and in the service window. A 1-to-0 transition has no effect, and `pipe_empty_i` has no effect. `svc_done_i` has no effect outside a service window. Service requests have no effect except in power-down.
- R9: Every bit of `aon_clk_en_o` is 1 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_ctrl_i | input | 1 | Software control bit; 1 = run, 1-to-0 transition requests power-down |
| pipe_empty_i | input | 1 | Memory pipeline holds no outstanding access |
| irq_i | input | 1 | Interrupt request, wakes the processor |
| refresh_req_i | input | 1 | Refresh cycle request, temporary wake-up |
| arb_req_i | input | 1 | Bus arbitration request, temporary wake-up |
| svc_done_i | input | 1 | Refresh or arbitration service finished |
| core_clk_en_o | output | N_CORE_DOM | Clock enables of the gated core domains |
| aon_clk_en_o | output | N_AON_DOM | Clock enables of the always-on domains |
| pd_state_o | output | 1 | Processor is in power-down |

## Verification
The bench goes after several corner cases.
- A control bit held at 0 after an interrupt wake-up. A level-sensitive design would fall straight back to sleep.
- A pipeline that stays busy for many cycles. A design that did not wait would stop the core with accesses still in flight.
- An interrupt in the same cycle as a fall, or during the drain wait. A design that ignored it would enter sleep anyway.
- Refresh and arbitration wake-ups that end with done. A faulty design could stay awake, or require a new fall before sleeping again.
- Fall, done and pipeline-empty pulses in the wrong states. Each must leave the enables untouched.

Long constrained-random runs mix all of these against a reference model of the rules above.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  typedef enum logic [1:0] {
    PD_RUN   = 2'd0,
    PD_DRAIN = 2'd1,
    PD_SLEEP = 2'd2,
    PD_WAKE  = 2'd3
  } pd_state_e;
endpackage

// File: rtl/pd_fall_det.sv
module pd_fall_det #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= RESET_VAL;
    else         lvl_q <= lvl_i;
  end

  // needs a sampled 1 before each counted 0
  assign fall_o = lvl_q & ~lvl_i;
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import pd_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      fall_i,
  input  logic      pipe_empty_i,
  input  logic      irq_i,
  input  logic      svc_req_i,
  input  logic      svc_done_i,
  output pd_state_e state_o
);
  pd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PD_RUN:   if (fall_i && !irq_i) state_d = PD_DRAIN;
      PD_DRAIN: begin
        if (irq_i)             state_d = PD_RUN;
        else if (pipe_empty_i) state_d = PD_SLEEP;
      end
      PD_SLEEP: begin
        if (irq_i)          state_d = PD_RUN;
        else if (svc_req_i) state_d = PD_WAKE;
      end
      PD_WAKE: begin
        if (irq_i)           state_d = PD_RUN;
        else if (svc_done_i) state_d = PD_SLEEP;
      end
      default: state_d = PD_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PD_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pd_clk_en_gen.sv
module pd_clk_en_gen
  import pd_seq_pkg::*;
#(
  parameter int N_CORE_DOM = 4,
  parameter int N_AON_DOM  = 4
) (
  input  pd_state_e              state_i,
  output logic [N_CORE_DOM-1:0]  core_en_o,
  output logic [N_AON_DOM-1:0]   aon_en_o,
  output logic                   pd_o
);
  logic core_run;

  assign core_run = (state_i != PD_SLEEP);

  for (genvar g = 0; g < N_CORE_DOM; g++) begin : g_core
    assign core_en_o[g] = core_run;
  end

  for (genvar g = 0; g < N_AON_DOM; g++) begin : g_aon
    assign aon_en_o[g] = 1'b1;
  end

  assign pd_o = (state_i == PD_SLEEP);
endmodule

// File: rtl/pwr_down_seq.sv
module pwr_down_seq
  import pd_seq_pkg::*;
#(
  parameter int N_CORE_DOM = 4,
  parameter int N_AON_DOM  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pd_ctrl_i,
  input  logic                  pipe_empty_i,
  input  logic                  irq_i,
  input  logic                  refresh_req_i,
  input  logic                  arb_req_i,
  input  logic                  svc_done_i,
  output logic [N_CORE_DOM-1:0] core_clk_en_o,
  output logic [N_AON_DOM-1:0]  aon_clk_en_o,
  output logic                  pd_state_o
);
  logic      ctrl_fall;
  logic      svc_req;
  pd_state_e state;

  assign svc_req = refresh_req_i | arb_req_i;

  pd_fall_det #(.RESET_VAL(1'b1)) u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (pd_ctrl_i),
    .fall_o (ctrl_fall)
  );

  pd_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fall_i       (ctrl_fall),
    .pipe_empty_i (pipe_empty_i),
    .irq_i        (irq_i),
    .svc_req_i    (svc_req),
    .svc_done_i   (svc_done_i),
    .state_o      (state)
  );

  pd_clk_en_gen #(
    .N_CORE_DOM (N_CORE_DOM),
    .N_AON_DOM  (N_AON_DOM)
  ) u_en (
    .state_i   (state),
    .core_en_o (core_clk_en_o),
    .aon_en_o  (aon_clk_en_o),
    .pd_o      (pd_state_o)
  );
endmodule

// File: rtl/pd_seq_chk.sv
module pd_seq_chk #(
  parameter int N_CORE_DOM = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  pipe_empty_i,
  input logic                  irq_i,
  input logic                  refresh_req_i,
  input logic                  arb_req_i,
  input logic                  svc_done_i,
  input logic [N_CORE_DOM-1:0] core_clk_en_o,
  input logic                  pd_state_o
);
  a_r4_pd_core_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_state_o |-> (core_clk_en_o == '0));

  a_r4_run_core_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_state_o |-> (&core_clk_en_o));

  a_r6_irq_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_state_o && irq_i) |=> !pd_state_o);

  a_r5_svc_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_state_o && !irq_i && (refresh_req_i || arb_req_i)) |=> !pd_state_o);

  a_r3_entry_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_state_o) |-> $past(pipe_empty_i || svc_done_i));
endmodule

bind pwr_down_seq pd_seq_chk #(.N_CORE_DOM(N_CORE_DOM)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pipe_empty_i  (pipe_empty_i),
  .irq_i         (irq_i),
  .refresh_req_i (refresh_req_i),
  .arb_req_i     (arb_req_i),
  .svc_done_i    (svc_done_i),
  .core_clk_en_o (core_clk_en_o),
  .pd_state_o    (pd_state_o)
);

// File: tb/pwr_down_seq_test.sv
`timescale 1ns/1ps
module pwr_down_seq_test;
  localparam int NC = 4;
  localparam int NA = 4;
  localparam int S_RUN = 0, S_DRAIN = 1, S_SLEEP = 2, S_WAKE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl = 1'b1, pipe = 1'b0, irq = 1'b0, rfr = 1'b0, arb = 1'b0, done = 1'b0;
  logic [NC-1:0] core_en;
  logic [NA-1:0] aon_en;
  logic pd;

  int checks = 0;
  int errors = 0;
  int m_state = S_RUN;
  logic m_prev = 1'b1;
  string m_tag = "R1";
  bit finished = 0;

  always #2 clk = ~clk;

  pwr_down_seq #(.N_CORE_DOM(NC), .N_AON_DOM(NA)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pd_ctrl_i(ctrl), .pipe_empty_i(pipe),
    .irq_i(irq), .refresh_req_i(rfr), .arb_req_i(arb), .svc_done_i(done),
    .core_clk_en_o(core_en), .aon_clk_en_o(aon_en), .pd_state_o(pd)
  );

  function automatic int next_state(int st, bit fall, bit pe, bit ir, bit sreq, bit dn,
                                    output string tag);
    tag = "R8";
    case (st)
      S_RUN:   begin
        tag = fall ? (ir ? "R7" : "R2") : "R7";
        return (fall && !ir) ? S_DRAIN : S_RUN;
      end
      S_DRAIN: begin
        if (ir) begin tag = "R6"; return S_RUN; end
        tag = "R3";
        return pe ? S_SLEEP : S_DRAIN;
      end
      S_SLEEP: begin
        if (ir) begin tag = "R6"; return S_RUN; end
        if (sreq) begin tag = "R5"; return S_WAKE; end
        tag = "R8"; return S_SLEEP;
      end
      default: begin
        if (ir) begin tag = "R6"; return S_RUN; end
        tag = dn ? "R5" : "R8";
        return dn ? S_SLEEP : S_WAKE;
      end
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_outs(string tag);
    logic [NC-1:0] exp_core;
    exp_core = (m_state == S_SLEEP) ? '0 : '1;
    check(tag, 32'(core_en), 32'(exp_core), "core_clk_en_o");
    check(tag, 32'(pd), 32'(m_state == S_SLEEP), "pd_state_o");
    check("R9", 32'(aon_en), 32'({NA{1'b1}}), "aon_clk_en_o");
  endtask

  // called at negedge: drive, step model at posedge, check at next negedge
  task automatic cyc(bit c, bit pe, bit ir, bit rr, bit ar, bit dn);
    bit fall;
    ctrl = c; pipe = pe; irq = ir; rfr = rr; arb = ar; done = dn;
    @(posedge clk);
    fall = m_prev && !c;
    m_prev = c;
    m_state = next_state(m_state, fall, pe, ir, rr || ar, dn, m_tag);
    @(negedge clk);
    check_outs(m_tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    check_outs("R1");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_outs("R1");

    // R1: 0 at first edge after reset counts as a fall
    cyc(0, 1, 0, 0, 0, 0);            // -> DRAIN
    cyc(0, 1, 0, 0, 0, 0);            // -> SLEEP (R3)
    check("R1", 32'(pd), 32'd1, "sleep after first-edge fall");
    // R8: done and pipe pulses in sleep ignored
    cyc(0, 1, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);            // R8 fall in sleep ignored
    // R5: refresh wake then done
    cyc(0, 0, 0, 1, 0, 0);
    check("R5", 32'(pd), 32'd0, "refresh wake");
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    check("R5", 32'(pd), 32'd1, "back to sleep after done");
    // R5: arbitration wake
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1);
    // R6: irq wakes; R7: ctrl still 0 keeps running
    cyc(0, 0, 1, 0, 0, 0);
    check("R6", 32'(pd), 32'd0, "irq wake");
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0, 0);
    check("R7", 32'(pd), 32'd0, "level 0 no re-entry");
    // R2/R3: new fall with long busy pipeline
    cyc(1, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0);
    check("R3", 32'(&core_en), 32'd1, "core on while draining");
    // R6: irq cancels drain
    cyc(0, 1, 1, 0, 0, 0);
    check("R6", 32'(pd), 32'd0, "drain cancelled");
    cyc(0, 1, 0, 0, 0, 0);
    // R7: fall together with irq dropped
    cyc(1, 1, 0, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    check("R7", 32'(pd), 32'd0, "fall with irq dropped");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit c;
      c = ($urandom_range(0, 7) == 0) ? !ctrl : ctrl;
      cyc(c, $urandom_range(0, 2) == 0, $urandom_range(0, 19) == 0,
          $urandom_range(0, 9) == 0, $urandom_range(0, 11) == 0,
          $urandom_range(0, 3) == 0);
    end
    finish_run();
  end
endmodule